// File: doc/BRIEF.md
# Dual-Channel Bus-Master Register File

This block holds the byte-wide control registers of a two-channel disk-interface DMA controller and merges the two channel interrupt requests into a single active-high interrupt line. Each channel owns an eight-byte window. Channel 0 starts at byte 0 of the region and channel 1 at byte 8, so the region spans 16 bytes. Each window holds a command byte, a channel status byte, a timing byte and a four-byte descriptor-table address. Byte 1 of either window reaches one mode register that both channels share. It records which channel interrupts are pending and which channels are masked.

Software reaches the block over a plain byte bus. A write takes effect at the clock edge that samples it. A read returns its data one cycle later, together with a one-cycle response strobe. The response has no back-pressure: the block accepts a request in every cycle and always answers one cycle later. The DMA engine drives two kinds of input. The first is a live "transfer active" level for each channel. The second is a set of one-cycle event pulses that set the two sticky status flags of each channel. The engine itself and the meaning of the command byte are outside this block. The command byte is only stored.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register reads 0x00 (apart from status bit 0, which shows the live `dma_active` input), `irq_out` is low and `rsp_valid` is low.
- R2: A read request (`rd_en` high at a clock edge) gives `rsp_valid` high for exactly the following cycle, with the data on `rdata` in that same cycle. A read of any address at or above 16 returns 0xFF.
- R3: Address bit 3 selects the channel window and bits 2:0 select the byte within it. 0 is command, 1 is the shared mode register, 2 is status, 3 is timing, and 4 to 7 are descriptor-address bytes 0 to 3 (little-endian, byte 4 is the least significant).
- R4: A write to byte 1 of either window changes only mode bits 5:4 (bit 4 masks channel 0, bit 5 masks channel 1). All other mode bits keep their values.
- R5: A status write loads status bits 6:5 from the data and clears status bits 2:1 wherever the data bit is 1. Status bit 0 always reads the channel's `dma_active` input and ignores writes. Status bits 7, 4 and 3 read 0.
- R6: `flag_set[2c]` sets status bit 1 and `flag_set[2c+1]` sets status bit 2 of channel c. A set and a write-one-to-clear of the same bit in the same cycle leave the bit at 1.
- R7: Mode bit 2+c follows the level of `chan_irq[c]` and is updated at the next clock edge.
- R8: `irq_out` equals (mode bit 2 AND NOT mode bit 4) OR (mode bit 3 AND NOT mode bit 5) and responds in the cycle after a `chan_irq` change or a mode write.
- R9: A write to byte 3 stores the whole byte in the timing register of the window's own channel, and leaves the other channel's timing byte unchanged.
- R10: Command and descriptor-address bytes store the whole written byte per channel, and a write to one channel leaves the other channel's bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write request |
| rd_en | input | 1 | Byte read request |
| addr | input | ADDR_W (6) | Byte address within the region |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rsp_valid` is high |
| rsp_valid | output | 1 | One-cycle read response strobe |
| chan_irq | input | 2 | Level interrupt request per channel |
| dma_active | input | 2 | Live transfer-active level per channel (status bit 0) |
| flag_set | input | 4 | Sticky flag set pulses, two per channel |
| irq_out | output | 1 | Combined active-high interrupt |

## Verification
The assertions take for granted that `chan_irq`, `dma_active` and `flag_set` are synchronous to `clk` and that `flag_set` is a pulse rather than a held level. They also assume that a write request carries a stable address and data for the edge that samples it. The stimulus changes every input only on the falling clock edge. It raises `flag_set` for a single cycle, and it deliberately overlaps a set pulse with a write-one-to-clear of the same bit so that the set-wins rule of R6 is exercised. The interrupt checks hold the mask bits still while they move `chan_irq`, which matches the precondition of the unmasked-interrupt property.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

  // Byte selector inside one channel window.
  typedef enum logic [2:0] {
    SEL_CMD  = 3'd0,
    SEL_MODE = 3'd1,
    SEL_STAT = 3'd2,
    SEL_TIME = 3'd3,
    SEL_AD0  = 3'd4,
    SEL_AD1  = 3'd5,
    SEL_AD2  = 3'd6,
    SEL_AD3  = 3'd7
  } win_sel_e;

  // Status byte fields: bit 0 live active, bits 2:1 sticky flags,
  // bits 6:5 software-owned.
  localparam int STAT_FLAG_LO = 1;
  localparam int STAT_SW_LO   = 5;

  // Shared mode byte fields.
  localparam int MODE_PEND_LO = 2;
  localparam int MODE_MASK_LO = 4;

  localparam logic [7:0] UNMAPPED_BYTE = 8'hFF;

endpackage

// File: rtl/dma_regbank_mode.sv
module dma_regbank_mode #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [NUM_CH-1:0] mask_wdata,
  input  logic [NUM_CH-1:0] chan_irq,
  output logic [7:0]        mode_byte,
  output logic              irq_out
);
  import dma_regbank_pkg::*;

  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= chan_irq;
      if (mode_wr) mask_q <= mask_wdata;
    end
  end

  always_comb begin
    mode_byte = '0;
    mode_byte[MODE_PEND_LO +: NUM_CH] = pend_q;
    mode_byte[MODE_MASK_LO +: NUM_CH] = mask_q;
  end

  assign irq_out = |(pend_q & ~mask_q);

  // R7: pending bits track the request levels one edge later
  p_pend_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq != pend_q) |=> (pend_q == $past(chan_irq)));

  // R4: masks move only on a mode write
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mask_q));

  // R8: no request means no interrupt
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq == '0) |=> !irq_out);

  // R8: an unmasked channel-0 request raises the output
  p_irq_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq[0] && !mode_wr && !mask_q[0]) |=> irq_out);

endmodule

// File: rtl/dma_regbank_chan.sv
module dma_regbank_chan #(
  parameter int ADDR_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [2:0] sel,
  input  logic [7:0] wdata,
  input  logic       dma_active,
  input  logic [1:0] flag_set,
  output logic [7:0] rd_byte
);
  import dma_regbank_pkg::*;

  localparam int AB_W = $clog2(ADDR_BYTES);

  logic [7:0] cmd_q;
  logic [7:0] time_q;
  logic [1:0] sw_q;
  logic [1:0] flag_q;
  logic [7:0] ad_q [ADDR_BYTES];

  logic wr_cmd, wr_stat, wr_time;
  assign wr_cmd  = wr_hit && (sel == SEL_CMD);
  assign wr_stat = wr_hit && (sel == SEL_STAT);
  assign wr_time = wr_hit && (sel == SEL_TIME);

  logic [1:0] clr_mask;
  assign clr_mask = wr_stat ? wdata[STAT_FLAG_LO +: 2] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      time_q <= '0;
      sw_q   <= '0;
      flag_q <= '0;
    end else begin
      if (wr_cmd)  cmd_q  <= wdata;
      if (wr_time) time_q <= wdata;
      if (wr_stat) sw_q   <= wdata[STAT_SW_LO +: 2];
      flag_q <= flag_set | (flag_q & ~clr_mask);
    end
  end

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_ad
    logic wr_ad;
    assign wr_ad = wr_hit && sel[2] && (sel[AB_W-1:0] == AB_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n)     ad_q[b] <= '0;
      else if (wr_ad) ad_q[b] <= wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_CMD:  rd_byte = cmd_q;
      SEL_MODE: rd_byte = 8'h00;
      SEL_STAT: rd_byte = {1'b0, sw_q, 2'b00, flag_q, dma_active};
      SEL_TIME: rd_byte = time_q;
      default:  rd_byte = ad_q[sel[AB_W-1:0]];
    endcase
  end

  // R5: writing a one clears a flag when no set arrives
  p_flag_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[STAT_FLAG_LO] && !flag_set[0]) |=> !flag_q[0]);

  // R6: flags hold without set or status write
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && flag_set == 2'b00) |=> $stable(flag_q));

  // R6: a set pulse always wins
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[1] |=> flag_q[1]);

  // R10, R9: stored bytes hold unless this window is written
  p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(cmd_q) && $stable(time_q)));

endmodule

// File: rtl/dma_regbank_rdport.sv
module dma_regbank_rdport (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       mapped,
  input  logic [7:0] sel_byte,
  output logic [7:0] rdata,
  output logic       rsp_valid
);
  import dma_regbank_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rdata     <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rdata <= mapped ? sel_byte : UNMAPPED_BYTE;
    end
  end

  // R2: one response per request, one cycle later
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);

  // R2: out-of-region reads answer all ones
  p_unmapped_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata == UNMAPPED_BYTE));

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank #(
  parameter int ADDR_W     = 6,
  parameter int WIN_BYTES  = 8,
  parameter int ADDR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rsp_valid,
  input  logic [1:0]        chan_irq,
  input  logic [1:0]        dma_active,
  input  logic [3:0]        flag_set,
  output logic              irq_out
);
  import dma_regbank_pkg::*;

  localparam int NUM_CH = 2;
  localparam int OFS_W  = $clog2(WIN_BYTES);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int REG_W  = OFS_W + CH_W;

  logic [OFS_W-1:0] sel;
  logic [CH_W-1:0]  win;
  logic             mapped;

  assign sel    = addr[OFS_W-1:0];
  assign win    = addr[OFS_W +: CH_W];
  assign mapped = (addr >> REG_W) == '0;

  logic [7:0] chan_rd [NUM_CH];
  logic [7:0] mode_byte;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_hit;
    assign wr_hit = wr_en && mapped && (win == CH_W'(c));
    dma_regbank_chan #(.ADDR_BYTES(ADDR_BYTES)) i_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (wr_hit),
      .sel        (sel),
      .wdata      (wdata),
      .dma_active (dma_active[c]),
      .flag_set   (flag_set[2*c +: 2]),
      .rd_byte    (chan_rd[c])
    );
  end

  logic mode_wr;
  assign mode_wr = wr_en && mapped && (sel == SEL_MODE);

  dma_regbank_mode #(.NUM_CH(NUM_CH)) i_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mask_wdata (wdata[MODE_MASK_LO +: NUM_CH]),
    .chan_irq   (chan_irq),
    .mode_byte  (mode_byte),
    .irq_out    (irq_out)
  );

  logic [7:0] sel_byte;
  assign sel_byte = (sel == SEL_MODE) ? mode_byte : chan_rd[win];

  dma_regbank_rdport i_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .mapped    (mapped),
    .sel_byte  (sel_byte),
    .rdata     (rdata),
    .rsp_valid (rsp_valid)
  );

  // R1: the combined interrupt is low while reset is applied
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !irq_out);

endmodule

// File: tb/test_dma_regbank.sv
module test_dma_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rsp_valid;
  logic [1:0] chan_irq = '0, dma_active = '0;
  logic [3:0] flag_set = '0;
  logic       irq_out;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_regbank i_dma_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rsp_valid(rsp_valid),
    .chan_irq(chan_irq), .dma_active(dma_active), .flag_set(flag_set),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R2 rsp_valid after read", {7'b0, rsp_valid}, 8'h01);
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse_flags(input logic [3:0] f);
    @(negedge clk); flag_set = f;
    @(negedge clk); flag_set = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq_out at reset", {7'b0, irq_out}, 8'h00);
    chk("R1 rsp_valid at reset", {7'b0, rsp_valid}, 8'h00);
    for (int a = 0; a < 16; a++) rd_chk("R1 register reset value", 6'(a), 8'h00);
  endtask

  task automatic t_unmapped;
    rd_chk("R2 unmapped read 16", 6'd16, 8'hFF);
    @(negedge clk);
    chk("R2 rsp_valid single cycle", {7'b0, rsp_valid}, 8'h00);
    rd_chk("R2 unmapped read 63", 6'd63, 8'hFF);
  endtask

  task automatic t_map;
    wr(6'd0, 8'hA5); wr(6'd8, 8'h5A);
    wr(6'd4, 8'h11); wr(6'd5, 8'h22); wr(6'd6, 8'h33); wr(6'd7, 8'h44);
    wr(6'd12, 8'hC1); wr(6'd15, 8'hF4);
    rd_chk("R10 cmd ch0", 6'd0, 8'hA5);
    rd_chk("R10 cmd ch1", 6'd8, 8'h5A);
    rd_chk("R3 addr byte0 ch0", 6'd4, 8'h11);
    rd_chk("R3 addr byte3 ch0", 6'd7, 8'h44);
    rd_chk("R10 addr byte0 ch1", 6'd12, 8'hC1);
    rd_chk("R10 addr byte1 ch1 untouched", 6'd13, 8'h00);
    rd_chk("R3 addr byte3 ch1", 6'd15, 8'hF4);
    wr(6'd3, 8'h3C);
    rd_chk("R9 timing ch1 unaffected", 6'd11, 8'h00);
    wr(6'd11, 8'hC3);
    rd_chk("R9 timing ch0", 6'd3, 8'h3C);
    rd_chk("R9 timing ch1", 6'd11, 8'hC3);
  endtask

  task automatic t_mode;
    wr(6'd1, 8'hFF);
    rd_chk("R4 mode only masks written", 6'd1, 8'h30);
    rd_chk("R3 mode shared via ch1 window", 6'd9, 8'h30);
    wr(6'd9, 8'h10);
    rd_chk("R4 mode written from ch1 window", 6'd1, 8'h10);
    wr(6'd1, 8'h00);
  endtask

  task automatic t_irq;
    @(negedge clk); chan_irq = 2'b01;
    @(negedge clk);
    chk("R8 ch0 unmasked irq", {7'b0, irq_out}, 8'h01);
    rd_chk("R7 pending ch0", 6'd1, 8'h04);
    wr(6'd1, 8'h10);
    chk("R8 ch0 masked", {7'b0, irq_out}, 8'h00);
    @(negedge clk); chan_irq = 2'b11;
    @(negedge clk);
    chk("R8 ch1 unmasked", {7'b0, irq_out}, 8'h01);
    rd_chk("R7 both pending", 6'd9, 8'h1C);
    wr(6'd1, 8'h30);
    chk("R8 both masked", {7'b0, irq_out}, 8'h00);
    @(negedge clk); chan_irq = 2'b00;
    @(negedge clk);
    rd_chk("R7 pending cleared on low level", 6'd1, 8'h30);
    wr(6'd1, 8'h00);
    @(negedge clk); chan_irq = 2'b10;
    @(negedge clk);
    chk("R8 ch1 alone", {7'b0, irq_out}, 8'h01);
    @(negedge clk); chan_irq = 2'b00;
    @(negedge clk);
    chk("R8 drops with request", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_status;
    pulse_flags(4'b0011);
    rd_chk("R6 flags set ch0", 6'd2, 8'h06);
    rd_chk("R6 ch1 flags untouched", 6'd10, 8'h00);
    @(negedge clk); dma_active = 2'b01;
    rd_chk("R5 bit0 live active", 6'd2, 8'h07);
    wr(6'd2, 8'hFF);
    rd_chk("R5 load 6:5 clear 2:1 keep 0", 6'd2, 8'h61);
    wr(6'd2, 8'h00);
    rd_chk("R5 bits 6:5 reloaded to zero", 6'd2, 8'h01);
    pulse_flags(4'b0011);
    wr(6'd2, 8'h02);
    rd_chk("R5 clear only bit1", 6'd2, 8'h05);
    @(negedge clk); addr = 6'd2; wdata = 8'h04; wr_en = 1'b1; flag_set = 4'b0010;
    @(negedge clk); wr_en = 1'b0; flag_set = '0;
    rd_chk("R6 set wins over clear", 6'd2, 8'h05);
    wr(6'd2, 8'h04);
    rd_chk("R5 clear bit2", 6'd2, 8'h01);
    @(negedge clk); dma_active = 2'b00;
    rd_chk("R5 bit0 follows input low", 6'd2, 8'h00);
    pulse_flags(4'b0100);
    rd_chk("R6 ch1 bit1 set", 6'd10, 8'h02);
    rd_chk("R6 ch0 unaffected by ch1 set", 6'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unmapped();
    t_map();
    t_mode();
    t_irq();
    t_status();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule